// File: doc/BRIEF.md
# Interrupt Controller Init Sequencer with Vector Rebase

This block is the register-write front end for a master/slave pair of 8259-style interrupt controllers. Byte writes arrive with a controller select, a single address bit and eight data bits. Each controller decodes its writes into initialization command words (ICW1 through ICW4) and into mask writes once it is running. Each controller exposes its vector base, its interrupt mask, an init-busy status and an interrupt vector built from the base and an IRQ index.

A second entry path lets software move a controller's vector base without re-initializing it. Writing the reserved command byte 0xFF at address 0 arms a one-shot flag. The next ICW2 then loads only the new base and returns the controller straight to normal operation. The mask and the stored mode stay as they were. The flag is a single bit shared by both controllers, so whichever controller takes the next ICW2 uses it up. Software must therefore not arm both controllers before either receives its ICW2.

Top module: `irq_init_front`

## Requirements
- R1: Only `wr_addr` is decoded. A write at address 0 with data bit 4 clear changes nothing visible: base, mask and busy all keep their values.
- R2: A write at address 0 with data bit 4 set and data not equal to 0xFF is a normal ICW1. From the next cycle the mask reads 0 and busy reads 1. Data bit 1 is stored as single mode (1 = single) and data bit 0 as "ICW4 expected".
- R3: An ICW2 write (address 1) loads the base with data AND 0xF8. From the next cycle the vector output equals base OR `irq_idx`.
- R4: In a normal sequence, ICW2 is followed by an ICW3 when in cascade mode and no ICW3 when in single mode. It is then followed by an ICW4 only when ICW4 was requested. Busy falls in the cycle after the last expected word.
- R5: A write of 0xFF at address 0 sets busy from the next cycle and leaves the mask and base unchanged.
- R6: An ICW2 that arrives while the shared flag is set loads the base and clears busy from the next cycle. It skips ICW3 and ICW4, and the next address-1 write loads the mask.
- R7: The shared flag is consumed by whichever controller next takes an ICW2. A controller that later takes an ICW2 without the flag follows its stored mode. A normal ICW1 neither sets nor clears the flag.
- R8: While a controller is not busy, an address-1 write loads its mask. The mask is preserved across a vector-rebase sequence.
- R9: Reset gives base 0, mask 0, busy 0 on both controllers and clears the shared flag.
- R10: A write with `wr_ctrl` selecting one controller (0 = master, 1 = slave) leaves the other controller's base, mask and busy unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_ctrl | input | 1 | Controller select: 0 master, 1 slave |
| wr_addr | input | 1 | Register address bit |
| wr_data | input | 8 | Write data |
| irq_idx | input | 3 | IRQ index used to form both vector outputs |
| master_base | output | 8 | Master vector base |
| slave_base | output | 8 | Slave vector base |
| master_mask | output | 8 | Master interrupt mask |
| slave_mask | output | 8 | Slave interrupt mask |
| master_busy | output | 1 | Master initialization in progress |
| slave_busy | output | 1 | Slave initialization in progress |
| master_vec | output | 8 | Master base OR irq_idx |
| slave_vec | output | 8 | Slave base OR irq_idx |

## Verification
The hardest state to reach is the shared flag being consumed by the controller that did not arm it. This leaves the arming controller waiting for an ICW2 that must now run the full normal path. The stimulus arms the master, fully initializes the slave in cascade mode, and shows that the slave skips its ICW3. It then gives the master its ICW2 and shows that the master still expects ICW3 and ICW4 from its earlier mode. A second directed case arms the flag, applies reset and shows that a cascade-mode sequence afterwards still waits for ICW3. This proves the flag was cleared, which no output shows directly.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DATA_W   = 8;
    localparam int IDX_W    = 3;
    localparam int NUM_CTRL = 2;

    localparam logic [DATA_W-1:0] REBASE_CODE = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] BASE_KEEP   = {{(DATA_W-IDX_W){1'b1}}, {IDX_W{1'b0}}};

    localparam int CMD_INIT_BIT = 4;
    localparam int CMD_SNGL_BIT = 1;
    localparam int CMD_IC4_BIT  = 0;

    typedef enum logic [1:0] {
        PH_RUN,
        PH_WANT2,
        PH_WANT3,
        PH_WANT4
    } phase_e;

    typedef struct packed {
        logic single;
        logic need4;
    } mode_t;

    typedef struct packed {
        logic              en;
        logic              addr;
        logic [DATA_W-1:0] data;
    } wr_t;

    function automatic logic is_rebase(input logic [DATA_W-1:0] d);
        return d == REBASE_CODE;
    endfunction

    function automatic logic is_init(input logic [DATA_W-1:0] d);
        return d[CMD_INIT_BIT] && (d != REBASE_CODE);
    endfunction

    function automatic phase_e after_base(input mode_t m);
        if (!m.single)
            return PH_WANT3;
        return m.need4 ? PH_WANT4 : PH_RUN;
    endfunction

endpackage

// File: rtl/irqc_rebase_flag.sv
module irqc_rebase_flag
    import irqc_pkg::*;
#(
    parameter int N = NUM_CTRL
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] arm,
    input  logic [N-1:0] take,
    output logic         pending
);

    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else if (|take)
            pending <= 1'b0;
        else if (|arm)
            pending <= 1'b1;
    end

endmodule

// File: rtl/irqc_unit.sv
module irqc_unit
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_t               wr,
    input  logic              rebase_pending,
    output logic              rebase_arm,
    output logic              rebase_take,
    output logic [DATA_W-1:0] base,
    output logic [DATA_W-1:0] mask,
    output logic              busy
);

    phase_e phase;
    mode_t  mode;

    always_comb begin
        rebase_arm  = wr.en && !wr.addr && is_rebase(wr.data);
        rebase_take = wr.en && wr.addr && (phase == PH_WANT2) && rebase_pending;
        busy        = (phase != PH_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_RUN;
            mode  <= '0;
            base  <= '0;
            mask  <= '0;
        end else if (wr.en) begin
            if (!wr.addr) begin
                if (is_rebase(wr.data)) begin
                    phase <= PH_WANT2;
                end else if (is_init(wr.data)) begin
                    phase       <= PH_WANT2;
                    mask        <= '0;
                    mode.single <= wr.data[CMD_SNGL_BIT];
                    mode.need4  <= wr.data[CMD_IC4_BIT];
                end
            end else begin
                unique case (phase)
                    PH_RUN:   mask <= wr.data;
                    PH_WANT2: begin
                        base  <= wr.data & BASE_KEEP;
                        phase <= rebase_pending ? PH_RUN : after_base(mode);
                    end
                    PH_WANT3: phase <= mode.need4 ? PH_WANT4 : PH_RUN;
                    PH_WANT4: phase <= PH_RUN;
                    default:  phase <= PH_RUN;
                endcase
            end
        end
    end

endmodule

// File: rtl/irq_init_front.sv
module irq_init_front
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  irq_idx,
    output logic [DATA_W-1:0] master_base,
    output logic [DATA_W-1:0] slave_base,
    output logic [DATA_W-1:0] master_mask,
    output logic [DATA_W-1:0] slave_mask,
    output logic              master_busy,
    output logic              slave_busy,
    output logic [DATA_W-1:0] master_vec,
    output logic [DATA_W-1:0] slave_vec
);

    logic [NUM_CTRL-1:0] arm_v;
    logic [NUM_CTRL-1:0] take_v;
    logic                pending;
    logic [DATA_W-1:0]   base_a [NUM_CTRL];
    logic [DATA_W-1:0]   mask_a [NUM_CTRL];
    logic [DATA_W-1:0]   vec_a  [NUM_CTRL];
    logic [NUM_CTRL-1:0] busy_v;

    irqc_rebase_flag #(.N(NUM_CTRL)) u_flag (
        .clk     (clk),
        .rst     (rst),
        .arm     (arm_v),
        .take    (take_v),
        .pending (pending)
    );

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_ctrl
        wr_t wr_g;
        always_comb begin
            wr_g.en   = wr_en && (wr_ctrl == 1'(g));
            wr_g.addr = wr_addr;
            wr_g.data = wr_data;
        end

        irqc_unit u_unit (
            .clk            (clk),
            .rst            (rst),
            .wr             (wr_g),
            .rebase_pending (pending),
            .rebase_arm     (arm_v[g]),
            .rebase_take    (take_v[g]),
            .base           (base_a[g]),
            .mask           (mask_a[g]),
            .busy           (busy_v[g])
        );

        assign vec_a[g] = base_a[g] | {{(DATA_W-IDX_W){1'b0}}, irq_idx};
    end

    assign master_base = base_a[0];
    assign slave_base  = base_a[1];
    assign master_mask = mask_a[0];
    assign slave_mask  = mask_a[1];
    assign master_busy = busy_v[0];
    assign slave_busy  = busy_v[1];
    assign master_vec  = vec_a[0];
    assign slave_vec   = vec_a[1];

endmodule

// File: rtl/irq_init_front_chk.sv
module irq_init_front_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       wr_ctrl,
    input logic       wr_addr,
    input logic [7:0] wr_data,
    input logic [7:0] master_base,
    input logic [7:0] master_mask,
    input logic       master_busy
);

    logic m_wr;
    assign m_wr = wr_en && !wr_ctrl;

    // R5
    rebase_keeps_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (m_wr && !wr_addr && wr_data == 8'hFF)
        |=> (master_busy && master_mask == $past(master_mask)
             && master_base == $past(master_base)));

    // R2
    init_clears_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (m_wr && !wr_addr && wr_data[4] && wr_data != 8'hFF)
        |=> (master_busy && master_mask == 8'h00));

    // R8
    run_write_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (m_wr && wr_addr && !master_busy)
        |=> (master_mask == $past(wr_data) && $stable(master_base) && !master_busy));

    // R10
    other_ctrl_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!m_wr) |=> ($stable(master_mask) && $stable(master_base) && $stable(master_busy)));

    // R1
    non_cmd_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (m_wr && !wr_addr && !wr_data[4])
        |=> ($stable(master_mask) && $stable(master_base) && $stable(master_busy)));

endmodule

bind irq_init_front irq_init_front_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_ctrl     (wr_ctrl),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .master_base (master_base),
    .master_mask (master_mask),
    .master_busy (master_busy)
);

// File: tb/irq_init_front_bench.sv
module irq_init_front_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_ctrl = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] irq_idx = 3'd0;
    logic [7:0] master_base, slave_base, master_mask, slave_mask, master_vec, slave_vec;
    logic       master_busy, slave_busy;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_init_front u_irq_init_front (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ctrl(wr_ctrl), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq_idx(irq_idx),
        .master_base(master_base), .slave_base(slave_base),
        .master_mask(master_mask), .slave_mask(slave_mask),
        .master_busy(master_busy), .slave_busy(slave_busy),
        .master_vec(master_vec), .slave_vec(slave_vec)
    );

    // entry: {ctrl, addr, data, exp_base, exp_mask, exp_busy, req}
    localparam int NV = 19;
    localparam logic [30:0] TBL [NV] = '{
        {1'b0, 1'b1, 8'h5A, 8'h00, 8'h5A, 1'b0, 4'd8},  // R8 mask while running
        {1'b0, 1'b0, 8'h08, 8'h00, 8'h5A, 1'b0, 4'd1},  // R1 bit4 clear ignored
        {1'b0, 1'b0, 8'h11, 8'h00, 8'h00, 1'b1, 4'd2},  // R2 cascade, ICW4 wanted
        {1'b0, 1'b1, 8'h47, 8'h40, 8'h00, 1'b1, 4'd3},  // R3 base 0x40
        {1'b0, 1'b1, 8'h04, 8'h40, 8'h00, 1'b1, 4'd4},  // R4 ICW3
        {1'b0, 1'b1, 8'h01, 8'h40, 8'h00, 1'b0, 4'd4},  // R4 ICW4 ends
        {1'b0, 1'b1, 8'hF0, 8'h40, 8'hF0, 1'b0, 4'd8},  // R8
        {1'b0, 1'b0, 8'hFF, 8'h40, 8'hF0, 1'b1, 4'd5},  // R5
        {1'b0, 1'b1, 8'h8B, 8'h88, 8'hF0, 1'b0, 4'd6},  // R6
        {1'b0, 1'b1, 8'h0F, 8'h88, 8'h0F, 1'b0, 4'd6},  // R6 next is mask
        {1'b1, 1'b0, 8'h13, 8'h00, 8'h00, 1'b1, 4'd2},  // R2 single, ICW4 wanted
        {1'b1, 1'b1, 8'h70, 8'h70, 8'h00, 1'b1, 4'd4},  // R4 skip ICW3
        {1'b1, 1'b1, 8'h03, 8'h70, 8'h00, 1'b0, 4'd4},  // R4 ICW4
        {1'b1, 1'b0, 8'h12, 8'h70, 8'h00, 1'b1, 4'd2},  // R2 single, no ICW4
        {1'b1, 1'b1, 8'h28, 8'h28, 8'h00, 1'b0, 4'd4},  // R4 done after ICW2
        {1'b1, 1'b1, 8'h33, 8'h28, 8'h33, 1'b0, 4'd8},  // R8
        {1'b1, 1'b0, 8'hFF, 8'h28, 8'h33, 1'b1, 4'd5},  // R5
        {1'b1, 1'b1, 8'hA9, 8'hA8, 8'h33, 1'b0, 4'd8},  // R8 mask kept across rebase
        {1'b1, 1'b1, 8'h55, 8'hA8, 8'h55, 1'b0, 4'd6}   // R6
    };

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic c, input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_ctrl = c; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic chk_m(input string req, input logic [7:0] b, input logic [7:0] m, input logic bz);
        chk(req, "master_base", master_base, b);
        chk(req, "master_mask", master_mask, m);
        chk(req, "master_busy", {7'd0, master_busy}, {7'd0, bz});
    endtask

    task automatic chk_s(input string req, input logic [7:0] b, input logic [7:0] m, input logic bz);
        chk(req, "slave_base", slave_base, b);
        chk(req, "slave_mask", slave_mask, m);
        chk(req, "slave_busy", {7'd0, slave_busy}, {7'd0, bz});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R9 reset state
        chk_m("R9", 8'h00, 8'h00, 1'b0);
        chk_s("R9", 8'h00, 8'h00, 1'b0);

        for (int i = 0; i < NV; i++) begin
            logic [30:0] e;
            string rq;
            e = TBL[i];
            wr(e[30], e[29], e[28:21]);
            rq = $sformatf("R%0d", e[3:0]);
            if (!e[30]) chk_m(rq, e[20:13], e[12:5], e[4]);
            else        chk_s(rq, e[20:13], e[12:5], e[4]);
        end

        // R10 master untouched by the slave rows
        chk_m("R10", 8'h88, 8'h0F, 1'b0);
        // R3 vector output
        irq_idx = 3'd5;
        #1;
        chk("R3", "master_vec", master_vec, 8'h8D);
        chk("R3", "slave_vec", slave_vec, 8'hAD);

        // R7 flag armed by master, consumed by slave
        wr(1'b0, 1'b0, 8'hFF);
        chk_m("R5", 8'h88, 8'h0F, 1'b1);
        wr(1'b1, 1'b0, 8'h10);              // slave normal ICW1, cascade
        chk_s("R2", 8'hA8, 8'h00, 1'b1);
        wr(1'b1, 1'b1, 8'h60);              // takes the shared flag
        chk_s("R7", 8'h60, 8'h00, 1'b0);
        chk_m("R10", 8'h88, 8'h0F, 1'b1);
        irq_idx = 3'd3;
        wr(1'b0, 1'b1, 8'h21);              // master ICW2 without flag
        chk_m("R7", 8'h20, 8'h0F, 1'b1);
        chk("R3", "master_vec", master_vec, 8'h23);
        wr(1'b0, 1'b1, 8'h04);              // ICW3
        chk_m("R7", 8'h20, 8'h0F, 1'b1);
        wr(1'b0, 1'b1, 8'h01);              // ICW4
        chk_m("R7", 8'h20, 8'h0F, 1'b0);

        // R9 reset clears a pending flag
        wr(1'b0, 1'b0, 8'hFF);
        do_reset();
        #1;
        chk_m("R9", 8'h00, 8'h00, 1'b0);
        chk_s("R9", 8'h00, 8'h00, 1'b0);
        wr(1'b1, 1'b0, 8'h10);
        wr(1'b1, 1'b1, 8'h40);
        chk_s("R9", 8'h40, 8'h00, 1'b1);

        // R1 address bit only; a bit-4-clear command while busy has no effect
        wr(1'b1, 1'b0, 8'h20);
        chk_s("R1", 8'h40, 8'h00, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule